// File: doc/BRIEF.md
# Combination-Key Input Decoder

This block reads five raw push switches (up, right, left, down, fire), all active low, and turns them into clean, active-high control bits for an arcade game. The same five switches drive both player 1 and player 2, so the direction and fire outputs are shared. The game's system functions (start 1, start 2, coin and reset) have no switches of their own. They are recognised as chords of the four direction keys.

Each switch is synchronised, then debounced against a slow tick. The filtered direction keys are decoded into a chord code. A chord fires only after its exact pattern has stayed unchanged for a qualification time. It then emits one pulse one clock wide. It cannot fire again until every direction key has been released. Movement outputs are blanked while opposing directions are held together, so a chord never appears as movement. A reset chord raises a reset request that stays high for a fixed number of clocks.

Top module: `combo_key_decoder`

## Requirements
- R1: `keys_ni` bit 0 is up, bit 1 right, bit 2 left, bit 3 down, bit 4 fire. A bit at 0 means pressed. After reset every output is 0.
- R2: When a single key is held steadily, its output (`up_o`, `right_o`, `left_o`, `down_o` or `fire_o`) goes high after the debounce delay. It stays high while the key is held and goes low after release. These outputs serve both players.
- R3: While left and right, or up and down, are pressed together, all four direction outputs are 0. Fire is not affected.
- R4: A key change shorter than (DEB_TICKS-1) slow ticks changes no output.
- R5: Left pressed with right released produces one `start1_o` pulse. Up and down do not matter for this chord.
- R6: Right pressed with left released produces one `start2_o` pulse.
- R7: Left, right and up pressed with down released produces one `coin1_o` pulse.
- R8: All four direction keys pressed produce a `rst_req_o` that stays high for exactly RST_HOLD consecutive clocks (default 16).
- R9: `coin2_o` is always 0.
- R10: Every chord pulse is one clock wide, and at most one chord output is high in any cycle. A chord held for any length of time fires once. Nothing more fires until all four direction keys have been released.
- R11: A chord pattern that lasts fewer than QUAL_TICKS slow ticks before changing into another pattern fires nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| keys_ni | input | 5 | Raw switches, active low: up, right, left, down, fire from bit 0 |
| up_o | output | 1 | Up, masked on opposing directions |
| right_o | output | 1 | Right, masked on opposing directions |
| left_o | output | 1 | Left, masked on opposing directions |
| down_o | output | 1 | Down, masked on opposing directions |
| fire_o | output | 1 | Fire level |
| start1_o | output | 1 | Start 1 pulse |
| start2_o | output | 1 | Start 2 pulse |
| coin1_o | output | 1 | Coin pulse |
| coin2_o | output | 1 | Second coin, always 0 |
| rst_req_o | output | 1 | Reset request, RST_HOLD clocks long |

## Verification
A level output settles at most 2 + (DEB_TICKS+1)·TICK_DIV + 2 clocks after a switch changes. A chord pulse follows within a further (QUAL_TICKS+1)·TICK_DIV + 2 clocks. The reset request then stays high for RST_HOLD clocks. With the bench parameters (4, 3, 4, 16) all of this ends well inside the 100 clocks for which the bench holds each switch pattern. The bench samples the levels at the end of each hold and counts pulses and reset-high cycles over the whole hold. No check depends on the phase of the slow tick. The glitch and staggered-chord cases are timed from that same tick period.

// File: rtl/ckd_pkg.sv
package ckd_pkg;
  localparam int N_KEYS  = 5;
  localparam int K_UP    = 0;
  localparam int K_RIGHT = 1;
  localparam int K_LEFT  = 2;
  localparam int K_DOWN  = 3;
  localparam int K_FIRE  = 4;

  typedef enum logic [2:0] {
    CH_NONE   = 3'd0,
    CH_START1 = 3'd1,
    CH_START2 = 3'd2,
    CH_COIN   = 3'd3,
    CH_RESET  = 3'd4
  } chord_e;
endpackage

// File: rtl/ckd_tick_gen.sv
module ckd_tick_gen #(
  parameter int DIV = 125000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == W'(DIV - 1)) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ckd_key_filter.sv
module ckd_key_filter #(
  parameter int DEB_TICKS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic key_ni,
  output logic pressed_o
);
  localparam int CW = (DEB_TICKS > 1) ? $clog2(DEB_TICKS) : 1;

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          lvl;

  assign lvl = ~sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q    <= 2'b11;
      cnt_q     <= '0;
      pressed_o <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], key_ni};
      if (lvl == pressed_o) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_q == CW'(DEB_TICKS - 1)) begin
          pressed_o <= lvl;
          cnt_q     <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ckd_chord_qual.sv
module ckd_chord_qual
  import ckd_pkg::*;
#(
  parameter int QUAL_TICKS = 50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [3:0] dir_i,
  output logic       start1_o,
  output logic       start2_o,
  output logic       coin_o,
  output logic       reset_o
);
  localparam int CW = (QUAL_TICKS > 1) ? $clog2(QUAL_TICKS) : 1;

  chord_e        code, code_q;
  logic [CW-1:0] cnt_q;
  logic          armed_q, hit, fire;
  logic          u, r, l, d;

  assign {d, l, r, u} = dir_i;

  always_comb begin
    if (l && r && u && d)  code = CH_RESET;
    else if (l && r && u)  code = CH_COIN;
    else if (l && !r)      code = CH_START1;
    else if (r && !l)      code = CH_START2;
    else                   code = CH_NONE;
  end

  assign hit  = tick_i && (code == code_q) && (code != CH_NONE) &&
                (cnt_q == CW'(QUAL_TICKS - 1));
  assign fire = hit && armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q   <= CH_NONE;
      cnt_q    <= '0;
      armed_q  <= 1'b1;
      start1_o <= 1'b0;
      start2_o <= 1'b0;
      coin_o   <= 1'b0;
      reset_o  <= 1'b0;
    end else begin
      code_q <= code;
      if (code != code_q)
        cnt_q <= '0;
      else if (tick_i && cnt_q != CW'(QUAL_TICKS - 1))
        cnt_q <= cnt_q + 1'b1;

      if (fire)             armed_q <= 1'b0;
      else if (dir_i == '0) armed_q <= 1'b1;

      start1_o <= fire && (code == CH_START1);
      start2_o <= fire && (code == CH_START2);
      coin_o   <= fire && (code == CH_COIN);
      reset_o  <= fire && (code == CH_RESET);
    end
  end
endmodule

// File: rtl/combo_key_decoder.sv
module combo_key_decoder
  import ckd_pkg::*;
#(
  parameter int TICK_DIV   = 125000,
  parameter int DEB_TICKS  = 10,
  parameter int QUAL_TICKS = 50,
  parameter int RST_HOLD   = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [4:0] keys_ni,
  output logic       up_o,
  output logic       right_o,
  output logic       left_o,
  output logic       down_o,
  output logic       fire_o,
  output logic       start1_o,
  output logic       start2_o,
  output logic       coin1_o,
  output logic       coin2_o,
  output logic       rst_req_o
);
  localparam int HW = $clog2(RST_HOLD + 1);

  logic              tick;
  logic [N_KEYS-1:0] pressed;
  logic [3:0]        dir_q;
  logic              fire_q, conflict, rst_fire;
  logic [HW-1:0]     hold_q;

  ckd_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  for (genvar k = 0; k < N_KEYS; k++) begin : g_key
    ckd_key_filter #(.DEB_TICKS(DEB_TICKS)) u_filt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .key_ni   (keys_ni[k]),
      .pressed_o(pressed[k])
    );
  end

  ckd_chord_qual #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .dir_i   (pressed[3:0]),
    .start1_o(start1_o),
    .start2_o(start2_o),
    .coin_o  (coin1_o),
    .reset_o (rst_fire)
  );

  // opposing pairs mean a chord is being entered, not movement
  assign conflict = (pressed[K_LEFT] && pressed[K_RIGHT]) ||
                    (pressed[K_UP] && pressed[K_DOWN]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      fire_q <= 1'b0;
      hold_q <= '0;
    end else begin
      dir_q  <= conflict ? 4'b0 : pressed[3:0];
      fire_q <= pressed[K_FIRE];
      if (rst_fire)         hold_q <= HW'(RST_HOLD);
      else if (hold_q != 0) hold_q <= hold_q - 1'b1;
    end
  end

  assign up_o      = dir_q[K_UP];
  assign right_o   = dir_q[K_RIGHT];
  assign left_o    = dir_q[K_LEFT];
  assign down_o    = dir_q[K_DOWN];
  assign fire_o    = fire_q;
  assign coin2_o   = 1'b0;
  assign rst_req_o = (hold_q != 0);
endmodule

// File: rtl/combo_key_decoder_chk.sv
module combo_key_decoder_chk #(
  parameter int RST_HOLD = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic up_o,
  input logic right_o,
  input logic left_o,
  input logic down_o,
  input logic start1_o,
  input logic start2_o,
  input logic coin1_o,
  input logic rst_req_o
);
  logic [15:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  run_q <= '0;
    else if (!rst_req_o)          run_q <= '0;
    else if (run_q != 16'hffff)   run_q <= run_q + 1'b1;
  end

  a_r3_no_opposing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(left_o && right_o) && !(up_o && down_o));

  a_r3_coin_no_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coin1_o |-> !left_o && !right_o);

  a_r10_one_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start1_o, start2_o, coin1_o}));

  a_r5_start1_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start1_o |=> !start1_o);

  a_r6_start2_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start2_o |=> !start2_o);

  a_r7_coin_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coin1_o |=> !coin1_o);

  a_r8_hold_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_o) |-> run_q == 16'(RST_HOLD));
endmodule

bind combo_key_decoder combo_key_decoder_chk #(.RST_HOLD(RST_HOLD)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .up_o     (up_o),
  .right_o  (right_o),
  .left_o   (left_o),
  .down_o   (down_o),
  .start1_o (start1_o),
  .start2_o (start2_o),
  .coin1_o  (coin1_o),
  .rst_req_o(rst_req_o)
);

// File: tb/tb_combo_key_decoder.sv
module tb_combo_key_decoder;
  localparam int TICK_DIV = 4, DEB = 3, QUAL = 4, HOLD = 16, WIN = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] keys_n = 5'h1f;
  logic up, rt, lf, dn, fr, s1, s2, c1, c2, rq;

  int checks = 0, errors = 0;
  int n_s1, n_s2, n_c1, n_rr, n_rh;
  bit armed = 1'b1, done = 1'b0;

  always #4 clk = ~clk;

  combo_key_decoder #(.TICK_DIV(TICK_DIV), .DEB_TICKS(DEB), .QUAL_TICKS(QUAL),
                      .RST_HOLD(HOLD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .keys_ni(keys_n),
    .up_o(up), .right_o(rt), .left_o(lf), .down_o(dn), .fire_o(fr),
    .start1_o(s1), .start2_o(s2), .coin1_o(c1), .coin2_o(c2), .rst_req_o(rq));

  logic rq_d = 1'b0;
  always @(negedge clk) begin
    n_s1 += int'(s1);
    n_s2 += int'(s2);
    n_c1 += int'(c1);
    n_rh += int'(rq);
    if (rq && !rq_d) n_rr++;
    rq_d = rq;
  end

  // 0 none, 1 start1, 2 start2, 3 coin, 4 reset
  function automatic int exp_code(input logic [4:0] p);
    if (p[2] && p[1] && p[0] && p[3]) return 4;
    if (p[2] && p[1] && p[0]) return 3;
    if (p[2] && !p[1]) return 1;
    if (p[1] && !p[2]) return 2;
    return 0;
  endfunction

  function automatic logic [3:0] exp_dirs(input logic [4:0] p);
    if ((p[1] && p[2]) || (p[0] && p[3])) return 4'b0;
    return p[3:0];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr();
    n_s1 = 0; n_s2 = 0; n_c1 = 0; n_rr = 0; n_rh = 0;
  endtask

  task automatic verify(input logic [4:0] p, input int code);
    logic [3:0] d;
    d = exp_dirs(p);
    chk("R1 R2 R3 up",    int'(up), int'(d[0]));
    chk("R1 R2 R3 right", int'(rt), int'(d[1]));
    chk("R1 R2 R3 left",  int'(lf), int'(d[2]));
    chk("R1 R2 R3 down",  int'(dn), int'(d[3]));
    chk("R2 fire",        int'(fr), int'(p[4]));
    chk("R5 R10 start1 pulses", n_s1, int'(code == 1));
    chk("R6 R10 start2 pulses", n_s2, int'(code == 2));
    chk("R7 R10 coin pulses",   n_c1, int'(code == 3));
    chk("R8 R10 reset events",  n_rr, int'(code == 4));
    chk("R8 reset high cycles", n_rh, (code == 4) ? HOLD : 0);
    chk("R9 coin2", int'(c2), 0);
  endtask

  task automatic apply(input logic [4:0] p);
    int code;
    clr();
    keys_n = ~p;
    repeat (WIN) @(negedge clk);
    code = (armed && exp_code(p) != 0) ? exp_code(p) : 0;
    if (code != 0) armed = 1'b0;
    if (p[3:0] == 4'b0) armed = 1'b1;
    verify(p, code);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", int'({up, rt, lf, dn, fr, s1, s2, c1, c2, rq}), 0);

    apply(5'b00001);  // up
    apply(5'b10001);  // up+fire
    apply(5'b00000);
    apply(5'b01000);  // down
    apply(5'b00000);
    apply(5'b00100);  // left -> start1
    apply(5'b00101);  // still start1 chord: no repeat
    apply(5'b00000);
    apply(5'b00100);  // re-armed
    apply(5'b00000);
    apply(5'b00010);  // right -> start2
    apply(5'b00000);
    apply(5'b00110);  // left+right: masked
    apply(5'b00000);
    apply(5'b11001);  // up+down+fire
    apply(5'b00000);
    apply(5'b00111);  // coin
    apply(5'b01111);  // reset chord blocked until release
    apply(5'b00000);
    apply(5'b01111);  // reset
    apply(5'b00000);

    // R4 glitch on left
    clr();
    keys_n = 5'b11011;
    repeat ((DEB - 1) * TICK_DIV - 3) @(negedge clk);
    keys_n = 5'h1f;
    repeat (WIN) @(negedge clk);
    chk("R4 glitch left", int'(lf), 0);
    chk("R4 glitch start1", n_s1, 0);

    // R11 coin pattern for 2 ticks, then reset chord
    clr();
    keys_n = ~5'b00111;
    repeat (2 * TICK_DIV) @(negedge clk);
    keys_n = ~5'b01111;
    repeat (WIN) @(negedge clk);
    chk("R11 no coin", n_c1, 0);
    chk("R11 reset fires", n_rr, 1);
    armed = 1'b0;
    apply(5'b00000);

    begin
      int seed;
      seed = $urandom(32'd2024);
      for (int i = 0; i < 60; i++) begin
        logic [4:0] p;
        p = 5'($urandom);
        if ($urandom % 4 == 0) p[3:0] = 4'b0;
        apply(p);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule